// File: doc/BRIEF.md
# Power-On Bank Fetch Sequencer

This block sits between the board reset source and the processor. After power-up, and after any later board reset, it keeps the processor in reset. During that time it fetches a saved configuration byte from the battery-backed RAM of the real-time clock. It does this by running two bus cycles on the multiplexed RTC bus and driving the RTC select and strobe lines itself.

The block has no way to drive the shared data bus. For the first cycle, the address phase, the RTC therefore latches whatever the pulled-up idle bus carries, which is 0xFF. The RAM decodes only seven address bits, so that value selects its highest location, 0x7F. In the second cycle, the read phase, the RTC places the contents of that location on the bus. The block captures the byte and gives it to the bank-select register with a one-cycle load pulse. Only then, and never before a minimum hold time has passed, does it release the processor reset. From that point on, the processor's own RTC control lines pass straight through to the device.

All phase lengths are set by parameters, so the sequence can be matched to the setup, strobe and hold times of the RTC part in use.

Top module: `bankFetchSeq`

## Requirements
- R1: While `extRstN` is low, `cpuRstN` is low and `rtcSel`, `rtcAddrStb` and `rtcRdStb` are all low.
- R2: The first rising edge of `cpuRstN` after a reset comes after the `bankLoad` pulse of that fetch.
- R3: After `extRstN` rises, `cpuRstN` stays low for at least `MIN_RST_CLKS` clock cycles, even when the fetch finishes sooner.
- R4: The address phase comes first. `rtcAddrStb` is high for exactly `STROBE_CLKS` cycles and `rtcRdStb` is low throughout. The block never drives the data bus, so the RTC latches the idle value 0xFF, which aliases to RAM location 0x7F.
- R5: The read phase begins only after `rtcAddrStb` has fallen. In it `rtcRdStb` is high for exactly `STROBE_CLKS` cycles. The two strobes are never high together.
- R6: During a fetch, `rtcSel` is high whenever either strobe is high.
- R7: The byte on `rtcData` during the read strobe appears on `bankData` together with a one-cycle `bankLoad` pulse. This happens exactly once per fetch.
- R8: Once `cpuRstN` is high, `rtcSel`, `rtcAddrStb` and `rtcRdStb` follow `cpuRtcSel`, `cpuAddrStb` and `cpuRdStb` combinationally.
- R9: While `cpuRstN` is low, the processor RTC inputs have no effect on the RTC outputs.
- R10: Pulling `extRstN` low in the middle of a fetch aborts it. When `extRstN` is released, a full new fetch runs and loads the byte then stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| extRstN | input | 1 | Board reset, active low, asynchronous assert |
| cpuRstN | output | 1 | Processor reset, active low |
| cpuRtcSel | input | 1 | Processor RTC select, passed through in run |
| cpuAddrStb | input | 1 | Processor RTC address strobe, passed through in run |
| cpuRdStb | input | 1 | Processor RTC read strobe, passed through in run |
| rtcSel | output | 1 | RTC chip select, active high |
| rtcAddrStb | output | 1 | RTC address latch strobe, active high |
| rtcRdStb | output | 1 | RTC read strobe, active high |
| rtcData | input | DATA_W | Multiplexed RTC data bus, pulled up when idle |
| bankLoad | output | 1 | One-cycle load pulse for the bank-select register |
| bankData | output | DATA_W | Captured byte for the bank-select register |

## Verification
The assertions assume that `extRstN` is released away from the clock edge and stays high once a fetch has begun, unless the bench is deliberately aborting that fetch. They also assume that `rtcData` is stable while the read strobe is high. The bench releases reset on a falling clock edge. Its RTC model holds the bus at 0xFF except during the read strobe, when it returns the stored byte only if the latched address aliases to 0x7F. Processor RTC inputs change only on falling edges, so any pass-through comparison samples settled values.

// File: rtl/bankFetchSeq_pkg.sv
package bankFetchSeq_pkg;

  typedef enum logic [3:0] {
    RESET_HOLD,
    ADDR_SETUP,
    ADDR_STROBE,
    ADDR_HOLD,
    DATA_SETUP,
    DATA_STROBE,
    LATCH,
    RELEASE,
    RUN
  } fetchState_t;

  typedef struct packed {
    logic selOn;
    logic addrOn;
    logic rdOn;
    logic capture;
    logic load;
    logic run;
  } fetchCtrl_t;

endpackage

// File: rtl/bankFetchSeq_ctrl.sv
module bankFetchSeq_ctrl
  import bankFetchSeq_pkg::*;
#(
  parameter int SETUP_CLKS  = 4,
  parameter int STROBE_CLKS = 8,
  parameter int HOLD_CLKS   = 4
) (
  input  logic       clk,
  input  logic       extRstN,
  input  logic       minDone,
  output fetchCtrl_t ctrl
);

  localparam int MAX_LEN = (SETUP_CLKS > STROBE_CLKS)
                           ? ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS)
                           : ((STROBE_CLKS > HOLD_CLKS) ? STROBE_CLKS : HOLD_CLKS);
  localparam int CW = $clog2(MAX_LEN + 1);

  fetchState_t state, nxtState;
  logic [CW-1:0] tmr;

  function automatic logic [CW-1:0] lenOf(input fetchState_t s);
    case (s)
      RESET_HOLD, ADDR_SETUP, DATA_SETUP: lenOf = CW'(SETUP_CLKS - 1);
      ADDR_STROBE, DATA_STROBE:           lenOf = CW'(STROBE_CLKS - 1);
      ADDR_HOLD:                          lenOf = CW'(HOLD_CLKS - 1);
      default:                            lenOf = '0;
    endcase
  endfunction

  always_comb begin
    nxtState = state;
    case (state)
      RUN:     nxtState = RUN;
      RELEASE: if (minDone) nxtState = RUN;
      default: if (tmr == '0) nxtState = fetchState_t'(state + 4'd1);
    endcase
  end

  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      state <= RESET_HOLD;
      tmr   <= lenOf(RESET_HOLD);
    end else begin
      state <= nxtState;
      if (nxtState != state) tmr <= lenOf(nxtState);
      else if (tmr != '0)    tmr <= tmr - 1'b1;
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.selOn   = (state >= ADDR_SETUP) && (state <= LATCH);
    ctrl.addrOn  = (state == ADDR_STROBE);
    ctrl.rdOn    = (state == DATA_STROBE);
    ctrl.capture = (state == DATA_STROBE) && (tmr == '0);
    ctrl.load    = (state == LATCH);
    ctrl.run     = (state == RUN);
  end

endmodule

// File: rtl/bankFetchSeq_dp.sv
module bankFetchSeq_dp
  import bankFetchSeq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int MIN_RST_CLKS = 256
) (
  input  logic              clk,
  input  logic              extRstN,
  input  fetchCtrl_t        ctrl,
  input  logic [DATA_W-1:0] rtcData,
  input  logic              cpuRtcSel,
  input  logic              cpuAddrStb,
  input  logic              cpuRdStb,
  output logic              rtcSel,
  output logic              rtcAddrStb,
  output logic              rtcRdStb,
  output logic              cpuRstN,
  output logic              bankLoad,
  output logic [DATA_W-1:0] bankData,
  output logic              minDone
);

  localparam int MW = $clog2(MIN_RST_CLKS + 1);
  localparam logic [MW-1:0] MIN_VAL = MW'(MIN_RST_CLKS);

  logic [DATA_W-1:0] capByte;
  logic [MW-1:0]     minCnt;

  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN)         capByte <= '0;
    else if (ctrl.capture) capByte <= rtcData;
  end

  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN)              minCnt <= '0;
    else if (minCnt != MIN_VAL) minCnt <= minCnt + 1'b1;
  end

  assign minDone    = (minCnt == MIN_VAL);
  assign rtcSel     = ctrl.run ? cpuRtcSel  : ctrl.selOn;
  assign rtcAddrStb = ctrl.run ? cpuAddrStb : ctrl.addrOn;
  assign rtcRdStb   = ctrl.run ? cpuRdStb   : ctrl.rdOn;
  assign cpuRstN    = ctrl.run;
  assign bankLoad   = ctrl.load;
  assign bankData   = capByte;

endmodule

// File: rtl/bankFetchSeq.sv
module bankFetchSeq
  import bankFetchSeq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SETUP_CLKS   = 4,
  parameter int STROBE_CLKS  = 8,
  parameter int HOLD_CLKS    = 4,
  parameter int MIN_RST_CLKS = 256
) (
  input  logic              clk,
  input  logic              extRstN,
  output logic              cpuRstN,
  input  logic              cpuRtcSel,
  input  logic              cpuAddrStb,
  input  logic              cpuRdStb,
  output logic              rtcSel,
  output logic              rtcAddrStb,
  output logic              rtcRdStb,
  input  logic [DATA_W-1:0] rtcData,
  output logic              bankLoad,
  output logic [DATA_W-1:0] bankData
);

  fetchCtrl_t ctrl;
  logic       minDone;

  bankFetchSeq_ctrl #(
    .SETUP_CLKS (SETUP_CLKS),
    .STROBE_CLKS(STROBE_CLKS),
    .HOLD_CLKS  (HOLD_CLKS)
  ) u_ctrl (
    .clk    (clk),
    .extRstN(extRstN),
    .minDone(minDone),
    .ctrl   (ctrl)
  );

  bankFetchSeq_dp #(
    .DATA_W      (DATA_W),
    .MIN_RST_CLKS(MIN_RST_CLKS)
  ) u_dp (
    .clk       (clk),
    .extRstN   (extRstN),
    .ctrl      (ctrl),
    .rtcData   (rtcData),
    .cpuRtcSel (cpuRtcSel),
    .cpuAddrStb(cpuAddrStb),
    .cpuRdStb  (cpuRdStb),
    .rtcSel    (rtcSel),
    .rtcAddrStb(rtcAddrStb),
    .rtcRdStb  (rtcRdStb),
    .cpuRstN   (cpuRstN),
    .bankLoad  (bankLoad),
    .bankData  (bankData),
    .minDone   (minDone)
  );

endmodule

// File: rtl/bankFetchSeq_chk.sv
module bankFetchSeq_chk #(
  parameter int MIN_RST_CLKS = 256
) (
  input logic clk,
  input logic extRstN,
  input logic cpuRstN,
  input logic cpuRtcSel,
  input logic cpuAddrStb,
  input logic cpuRdStb,
  input logic rtcSel,
  input logic rtcAddrStb,
  input logic rtcRdStb,
  input logic bankLoad
);

  localparam int CW = $clog2(MIN_RST_CLKS + 1);
  localparam logic [CW-1:0] MIN_VAL = CW'(MIN_RST_CLKS);

  logic [CW-1:0] sinceRst;
  logic          loaded;

  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      sinceRst <= '0;
      loaded   <= 1'b0;
    end else begin
      if (sinceRst != MIN_VAL) sinceRst <= sinceRst + 1'b1;
      if (bankLoad)            loaded   <= 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!extRstN)
      assert_reset_quiet_R1: assert (!cpuRstN && !rtcSel && !rtcAddrStb && !rtcRdStb);
  end

  assert_load_first_R2: assert property (@(posedge clk) disable iff (!extRstN)
    $rose(cpuRstN) |-> loaded);

  assert_min_hold_R3: assert property (@(posedge clk) disable iff (!extRstN)
    $rose(cpuRstN) |-> (sinceRst >= MIN_VAL));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!extRstN)
    !cpuRstN |-> !(rtcAddrStb && rtcRdStb));

  assert_sel_covers_R6: assert property (@(posedge clk) disable iff (!extRstN)
    (!cpuRstN && (rtcAddrStb || rtcRdStb)) |-> rtcSel);

  assert_single_load_R7: assert property (@(posedge clk) disable iff (!extRstN)
    bankLoad |-> (!loaded && !cpuRstN));

  assert_pass_R8: assert property (@(posedge clk) disable iff (!extRstN)
    cpuRstN |-> (rtcSel == cpuRtcSel && rtcAddrStb == cpuAddrStb && rtcRdStb == cpuRdStb));

endmodule

bind bankFetchSeq bankFetchSeq_chk #(.MIN_RST_CLKS(MIN_RST_CLKS)) u_chk (
  .clk       (clk),
  .extRstN   (extRstN),
  .cpuRstN   (cpuRstN),
  .cpuRtcSel (cpuRtcSel),
  .cpuAddrStb(cpuAddrStb),
  .cpuRdStb  (cpuRdStb),
  .rtcSel    (rtcSel),
  .rtcAddrStb(rtcAddrStb),
  .rtcRdStb  (rtcRdStb),
  .bankLoad  (bankLoad)
);

// File: tb/bankFetchSeq_tb.sv
`timescale 1ns/1ps
module bankFetchSeq_tb;

  localparam int SETUP_C  = 2;
  localparam int STROBE_C = 3;
  localparam int HOLD_C   = 2;
  localparam int MIN_C    = 24;

  logic       clk = 1'b0;
  logic       extRstN = 1'b0;
  logic       cpuRtcSel = 1'b0, cpuAddrStb = 1'b0, cpuRdStb = 1'b0;
  logic       cpuRstN, rtcSel, rtcAddrStb, rtcRdStb, bankLoad;
  logic [7:0] rtcData, bankData;

  logic [7:0] storedByte = 8'h00;
  logic [7:0] rawAddr = 8'h00;
  logic [6:0] latchedAddr = 7'h00;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  bankFetchSeq #(
    .DATA_W(8), .SETUP_CLKS(SETUP_C), .STROBE_CLKS(STROBE_C),
    .HOLD_CLKS(HOLD_C), .MIN_RST_CLKS(MIN_C)
  ) u_dut (
    .clk(clk), .extRstN(extRstN), .cpuRstN(cpuRstN),
    .cpuRtcSel(cpuRtcSel), .cpuAddrStb(cpuAddrStb), .cpuRdStb(cpuRdStb),
    .rtcSel(rtcSel), .rtcAddrStb(rtcAddrStb), .rtcRdStb(rtcRdStb),
    .rtcData(rtcData), .bankLoad(bankLoad), .bankData(bankData)
  );

  // RTC model: pulled-up bus, 7-bit address latch, only location 0x7F holds the byte
  assign rtcData = (rtcSel && rtcRdStb) ? ((latchedAddr == 7'h7F) ? storedByte : 8'h00) : 8'hFF;
  always @(negedge rtcAddrStb) begin
    rawAddr     = rtcData;
    latchedAddr = rtcData[6:0];
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic holdReset();
    @(negedge clk);
    extRstN = 1'b0;
    cpuRtcSel = 1'b1; cpuAddrStb = 1'b1; cpuRdStb = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cpuRstN low in reset", cpuRstN == 1'b0, cpuRstN, 0);
    chk("R1 rtc lines low in reset", {rtcSel, rtcAddrStb, rtcRdStb} == 3'b000,
        {rtcSel, rtcAddrStb, rtcRdStb}, 0);
  endtask

  // release reset with CPU RTC inputs held high, watch a full fetch
  task automatic runFetch(input logic [7:0] val);
    int lowCycles = 0, addrW = 0, rdW = 0, loads = 0, overlap = 0;
    int rdEarly = 0, selMiss = 0, loadVal = -1, loadAfterRun = 0;
    bit addrDone = 0, firstSel = 0;
    storedByte = val;
    latchedAddr = 7'h00;
    rawAddr = 8'h00;
    extRstN = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (cpuRstN) begin
        if (bankLoad) loadAfterRun++;
        break;
      end
      lowCycles++;
      if (i == 0) firstSel = rtcSel;
      if (rtcAddrStb) addrW++;
      if (rtcAddrStb && rtcRdStb) overlap++;
      if (!rtcAddrStb && addrW > 0) addrDone = 1;
      if (rtcRdStb) begin
        rdW++;
        if (!addrDone) rdEarly++;
      end
      if ((rtcAddrStb || rtcRdStb) && !rtcSel) selMiss++;
      if (bankLoad) begin
        loads++;
        loadVal = bankData;
      end
    end
    chk("R9 inputs ignored right after reset", firstSel == 1'b0, firstSel, 0);
    chk("R4 address strobe width", addrW == STROBE_C, addrW, STROBE_C);
    chk("R4 idle bus used as address", rawAddr == 8'hFF, rawAddr, 8'hFF);
    chk("R4 address aliases to 0x7F", latchedAddr == 7'h7F, latchedAddr, 7'h7F);
    chk("R5 read strobe width", rdW == STROBE_C, rdW, STROBE_C);
    chk("R5 read after address and no overlap", (rdEarly + overlap) == 0, rdEarly + overlap, 0);
    chk("R6 select covers strobes", selMiss == 0, selMiss, 0);
    chk("R7 single load pulse", loads == 1, loads, 1);
    chk("R7 loaded byte", loadVal == int'(val), loadVal, val);
    chk("R2 load before release", loads == 1 && cpuRstN == 1'b1, loads, 1);
    chk("R3 minimum reset hold", lowCycles >= MIN_C && lowCycles <= MIN_C + 2, lowCycles, MIN_C);
    cpuRtcSel = 1'b0; cpuAddrStb = 1'b0; cpuRdStb = 1'b0;
    @(negedge clk);
    chk("R7 no load in run", loadAfterRun == 0 && bankLoad == 1'b0, bankLoad, 0);
  endtask

  task automatic passThrough();
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      {cpuRtcSel, cpuAddrStb, cpuRdStb} = 3'(p);
      #2;
      chk("R8 pass-through in run", {rtcSel, rtcAddrStb, rtcRdStb} == 3'(p),
          {rtcSel, rtcAddrStb, rtcRdStb}, p);
    end
    chk("R8 cpu reset stays released", cpuRstN == 1'b1, cpuRstN, 1);
  endtask

  task automatic abortFetch();
    int seen = 0;
    cpuRtcSel = 1'b0; cpuAddrStb = 1'b0; cpuRdStb = 1'b0;
    extRstN = 1'b1;
    for (int i = 0; i < 100 && seen == 0; i++) begin
      @(negedge clk);
      if (rtcAddrStb) seen = 1;
    end
    chk("R10 fetch started before abort", seen == 1, seen, 1);
    #3 extRstN = 1'b0;
    #2;
    chk("R10 abort reasserts cpu reset", cpuRstN == 1'b0, cpuRstN, 0);
    chk("R10 abort drops rtc lines", {rtcSel, rtcAddrStb, rtcRdStb} == 3'b000,
        {rtcSel, rtcAddrStb, rtcRdStb}, 0);
    holdReset();
    runFetch(8'h5D);
  endtask

  initial begin
    #3_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    holdReset();
    runFetch(8'hA6);
    passThrough();
    holdReset();
    runFetch(8'hF3);
    holdReset();
    abortFetch();
    passThrough();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule